// File: doc/BRIEF.md
# Key-Protected Sequence Table

This block stores the instruction sequences that a serial-memory sequence engine steps through. It holds sixteen sequences, each made of four 32-bit instruction words, in flops that clear to zero (an all-stop program) at reset. Software reaches the table through a plain address/data/write-enable register port. The sequence engine reads one whole sequence at a time through a separate combinational read port selected by a sequence number.

The table is guarded by a two-step lock. The table starts locked, and while locked, writes to it are dropped without any response. Unlocking or relocking takes a write of the magic key to the key register, followed directly by a write to the lock-control register. Any other write in between, a wrong key value, or a lock-control write that is not preceded by a key write, leaves the lock state as it was. Each lock-control write uses up the armed key. The engine-side read port and the register read data always show the stored contents, whether the table is locked or not.

Top module: `keyed_seq_table`

## Requirements
- R1: Word k (0..3) of sequence s (0..15) sits at byte address 0x310 + s*16 + k*4. A table write while unlocked is visible from the next clock edge on seq_words[k*32 +: 32] when seq_sel equals s.
- R2: After reset, table_locked is 1 and all 64 stored words read as zero.
- R3: A table write while table_locked is 1 leaves every stored word unchanged.
- R4: Writing 0x5AF05AF0 to address 0x300 arms the key. When the very next write goes to address 0x304 with bit 1 set and bit 0 clear, the table unlocks. With bit 0 set, it locks. The change shows on table_locked after that write's clock edge.
- R5: A lock-control write has no effect on the lock state unless the immediately preceding write was the correct key. A wrong key value, or any write to another address between the key and the lock-control write, disarms the key.
- R6: Every lock-control write consumes the armed key, so a second lock-control write without a new key write is ignored.
- R7: When the key is armed, a lock-control value with both bit 0 and bit 1 set locks the table. A value with neither bit set changes nothing but still consumes the key.
- R8: seq_words shows the stored contents of sequence seq_sel whether the table is locked or unlocked.
- R9: reg_rdata returns the stored word for a table address, the lock state in bit 0 (other bits zero) at 0x304, and zero at every other address, including 0x300.
- R10: A write to a table address whose two low address bits are not both zero changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data for reg_addr |
| seq_sel | input | 4 | Sequence number for the engine read port |
| seq_words | output | 128 | Four words of the selected sequence, word 0 in the low bits |
| table_locked | output | 1 | 1 while table writes are blocked |

## Verification
The assertions assume that reg_we, reg_addr and reg_wdata are stable and known around each rising edge, and that seq_sel changes only when the table contents are meant to be compared across cycles. The stability property for locked contents therefore takes a steady seq_sel as its condition. The bench drives every input on the falling edge and keeps each write strobe to a single cycle. This way the key-then-command ordering is set only by the order of the write tasks, and no two writes ever merge.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

   localparam int          DEF_DATA_W    = 32;
   localparam int          DEF_ADDR_W    = 12;
   localparam int          DEF_NUM_SEQ   = 16;
   localparam int          DEF_WORDS     = 4;
   localparam int          DEF_KEY_OFS   = 'h300;
   localparam int          DEF_CTL_OFS   = 'h304;
   localparam int          DEF_TABLE_OFS = 'h310;
   localparam logic [31:0] DEF_KEY       = 32'h5AF0_5AF0;
   localparam int          DEF_LOCK_BIT  = 0;
   localparam int          DEF_OPEN_BIT  = 1;

   typedef enum logic [1:0] {
      HIT_NONE  = 2'd0,
      HIT_KEY   = 2'd1,
      HIT_CTL   = 2'd2,
      HIT_TABLE = 2'd3
   } hit_kind_e;

endpackage

// File: rtl/seqtab_decode.sv
module seqtab_decode
   import seqtab_pkg::*;
#(
   parameter int ADDR_W    = DEF_ADDR_W,
   parameter int KEY_OFS   = DEF_KEY_OFS,
   parameter int CTL_OFS   = DEF_CTL_OFS,
   parameter int TABLE_OFS = DEF_TABLE_OFS,
   parameter int ENTRIES   = DEF_NUM_SEQ * DEF_WORDS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   output hit_kind_e         hit,
   output logic              key_we,
   output logic              ctl_we,
   output logic [IDX_W-1:0]  tab_idx,
   output logic [ENTRIES-1:0] tab_sel
);

   localparam int SPAN = ENTRIES * 4;

   if (TABLE_OFS + SPAN > (1 << ADDR_W)) begin : g_bad_addr_w
      $fatal(1, "table window does not fit in ADDR_W");
   end
   if ((TABLE_OFS % 4) != 0) begin : g_bad_align
      $fatal(1, "table base must be word aligned");
   end

   logic [31:0] a32;
   logic [31:0] offs;
   logic        in_win;

   always_comb begin
      a32    = 32'(addr);
      offs   = a32 - 32'(TABLE_OFS);
      in_win = (a32 >= 32'(TABLE_OFS)) && (offs < 32'(SPAN));
      if (a32 == 32'(KEY_OFS))
         hit = HIT_KEY;
      else if (a32 == 32'(CTL_OFS))
         hit = HIT_CTL;
      else if (in_win && (addr[1:0] == 2'b00))
         hit = HIT_TABLE;
      else
         hit = HIT_NONE;
      tab_idx = IDX_W'(offs >> 2);
      key_we  = we && (hit == HIT_KEY);
      ctl_we  = we && (hit == HIT_CTL);
      tab_sel = (we && (hit == HIT_TABLE)) ? (ENTRIES'(1) << tab_idx) : '0;
   end

endmodule

// File: rtl/seqtab_keylock.sv
module seqtab_keylock
   import seqtab_pkg::*;
#(
   parameter int                DATA_W   = DEF_DATA_W,
   parameter logic [DATA_W-1:0] KEY      = DATA_W'(DEF_KEY),
   parameter int                LOCK_BIT = DEF_LOCK_BIT,
   parameter int                OPEN_BIT = DEF_OPEN_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_we,
   input  logic              key_we,
   input  logic              ctl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              locked,
   output logic              armed
);

   if (LOCK_BIT == OPEN_BIT || LOCK_BIT >= DATA_W || OPEN_BIT >= DATA_W) begin : g_bad_bits
      $fatal(1, "lock and unlock bits must be distinct and inside the data word");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         locked <= 1'b1;
      end else if (any_we) begin
         armed <= key_we && (wdata == KEY);
         if (ctl_we && armed) begin
            if (wdata[LOCK_BIT])
               locked <= 1'b1;
            else if (wdata[OPEN_BIT])
               locked <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/seqtab_store.sv
module seqtab_store
   import seqtab_pkg::*;
#(
   parameter int  NUM_SEQ = DEF_NUM_SEQ,
   parameter int  WORDS   = DEF_WORDS,
   parameter int  DATA_W  = DEF_DATA_W,
   localparam int ENTRIES = NUM_SEQ * WORDS,
   localparam int IDX_W   = $clog2(ENTRIES),
   localparam int SEL_W   = $clog2(NUM_SEQ),
   localparam int ROW_W   = WORDS * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] wr_sel,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [SEL_W-1:0]   seq_sel,
   output logic [ROW_W-1:0]   seq_words,
   input  logic [IDX_W-1:0]   word_idx,
   output logic [DATA_W-1:0]  word_rd
);

   logic [ENTRIES*DATA_W-1:0] flat;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (wr_sel[e])
            q <= wdata;
      end
      assign flat[e*DATA_W +: DATA_W] = q;
   end

   assign seq_words = flat[seq_sel*ROW_W +: ROW_W];
   assign word_rd   = flat[word_idx*DATA_W +: DATA_W];

endmodule

// File: rtl/keyed_seq_table.sv
module keyed_seq_table
   import seqtab_pkg::*;
#(
   parameter int                DATA_W    = DEF_DATA_W,
   parameter int                ADDR_W    = DEF_ADDR_W,
   parameter int                NUM_SEQ   = DEF_NUM_SEQ,
   parameter int                WORDS     = DEF_WORDS,
   parameter int                KEY_OFS   = DEF_KEY_OFS,
   parameter int                CTL_OFS   = DEF_CTL_OFS,
   parameter int                TABLE_OFS = DEF_TABLE_OFS,
   parameter logic [DATA_W-1:0] KEY       = DATA_W'(DEF_KEY),
   parameter int                LOCK_BIT  = DEF_LOCK_BIT,
   parameter int                OPEN_BIT  = DEF_OPEN_BIT,
   localparam int               SEL_W     = $clog2(NUM_SEQ),
   localparam int               ROW_W     = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [SEL_W-1:0]  seq_sel,
   output logic [ROW_W-1:0]  seq_words,
   output logic              table_locked
);

   localparam int ENTRIES = NUM_SEQ * WORDS;
   localparam int IDX_W   = $clog2(ENTRIES);

   if (NUM_SEQ < 2 || (1 << SEL_W) != NUM_SEQ) begin : g_bad_nseq
      $fatal(1, "NUM_SEQ must be a power of two of at least 2");
   end
   if (WORDS * DATA_W / 8 != 16) begin : g_bad_stride
      $fatal(1, "a sequence must span 16 bytes");
   end

   hit_kind_e          hit;
   logic               key_we;
   logic               ctl_we;
   logic [IDX_W-1:0]   tab_idx;
   logic [ENTRIES-1:0] tab_sel;
   logic               locked;
   logic               armed;
   logic [DATA_W-1:0]  word_rd;

   seqtab_decode #(
      .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .CTL_OFS(CTL_OFS),
      .TABLE_OFS(TABLE_OFS), .ENTRIES(ENTRIES)
   ) u_decode (
      .we(reg_we), .addr(reg_addr), .hit(hit), .key_we(key_we),
      .ctl_we(ctl_we), .tab_idx(tab_idx), .tab_sel(tab_sel)
   );

   seqtab_keylock #(
      .DATA_W(DATA_W), .KEY(KEY), .LOCK_BIT(LOCK_BIT), .OPEN_BIT(OPEN_BIT)
   ) u_keylock (
      .clk(clk), .rst_n(rst_n), .any_we(reg_we), .key_we(key_we),
      .ctl_we(ctl_we), .wdata(reg_wdata), .locked(locked), .armed(armed)
   );

   seqtab_store #(
      .NUM_SEQ(NUM_SEQ), .WORDS(WORDS), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .wr_sel(tab_sel & {ENTRIES{~locked}}),
      .wdata(reg_wdata), .seq_sel(seq_sel), .seq_words(seq_words),
      .word_idx(tab_idx), .word_rd(word_rd)
   );

   always_comb begin
      unique case (hit)
         HIT_TABLE: reg_rdata = word_rd;
         HIT_CTL:   reg_rdata = DATA_W'(locked);
         default:   reg_rdata = '0;
      endcase
   end

   assign table_locked = locked;

   // R4 / R5: the lock state moves only on a lock-control write that follows an armed key
   assert_lock_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(locked) |-> $past(ctl_we && armed));

   // R4 / R7: unlocking needs the unlock bit without the lock bit
   assert_unlock_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(reg_wdata[OPEN_BIT] && !reg_wdata[LOCK_BIT]));

   // R6: every lock-control write leaves the key disarmed
   assert_ctl_consumes_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> !armed);

   // R3: while locked, the selected sequence cannot change under a steady selection
   assert_locked_table_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(locked) && $stable(seq_sel)) |-> $stable(seq_words));

endmodule

// File: tb/keyed_seq_table_bench.sv
module keyed_seq_table_bench;

   localparam logic [31:0] KEYV = 32'h5AF0_5AF0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [3:0]   seq_sel = '0;
   logic [127:0] seq_words;
   logic         table_locked;

   int n_run  = 0;
   int n_fail = 0;

   always #4ns clk = ~clk;

   keyed_seq_table u_keyed_seq_table (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_sel(seq_sel),
      .seq_words(seq_words), .table_locked(table_locked)
   );

   function automatic logic [31:0] pat(int s, int k, int v);
      return {8'(v), 8'(s), 8'(k), 8'(s ^ k ^ 'h5A)};
   endfunction

   function automatic logic [11:0] waddr(int s, int k);
      return 12'('h310 + s * 16 + k * 4);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic check_row(string req, int s, int v);
      seq_sel = 4'(s);
      #1ns;
      for (int k = 0; k < 4; k++)
         chk(req, seq_words[k*32 +: 32], (v < 0) ? 32'h0 : pat(s, k, v));
   endtask

   task automatic check_all(string req, int v);
      for (int s = 0; s < 16; s++) check_row(req, s, v);
   endtask

   task automatic check_lock(string req, logic exp);
      #1ns;
      chk(req, 32'(table_locked), 32'(exp));
   endtask

   initial begin
      #(8ns * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2: reset state
      check_lock("R2", 1'b1);
      check_all("R2", -1);

      // R3: locked writes dropped
      for (int s = 0; s < 16; s++)
         for (int k = 0; k < 4; k++) wr(waddr(s, k), pat(s, k, 7));
      check_all("R3", -1);

      // R4: key then unlock
      wr(12'h300, KEYV); wr(12'h304, 32'h2);
      check_lock("R4", 1'b0);

      // R1: fill table, read via engine port; R9 via register port
      for (int s = 0; s < 16; s++)
         for (int k = 0; k < 4; k++) wr(waddr(s, k), pat(s, k, 1));
      check_all("R1", 1);
      for (int s = 0; s < 16; s += 5)
         for (int k = 0; k < 4; k++) begin
            reg_addr = waddr(s, k); #1ns;
            chk("R9", reg_rdata, pat(s, k, 1));
         end
      reg_addr = 12'h304; #1ns; chk("R9", reg_rdata, 32'h0);
      reg_addr = 12'h300; #1ns; chk("R9", reg_rdata, 32'h0);
      reg_addr = 12'h308; #1ns; chk("R9", reg_rdata, 32'h0);

      // R10: misaligned table writes ignored while unlocked
      wr(12'h311, 32'hDEAD_BEEF); wr(12'h31E, 32'hDEAD_BEEF);
      check_row("R10", 0, 1);
      check_row("R10", 0, 1);
      seq_sel = 4'd0; #1ns; chk("R10", seq_words[127:96], pat(0, 3, 1));

      // R4: key then lock
      wr(12'h300, KEYV); wr(12'h304, 32'h1);
      check_lock("R4", 1'b1);
      reg_addr = 12'h304; #1ns; chk("R9", reg_rdata, 32'h1);

      // R3 / R8: locked overwrite attempt, reads still show contents
      for (int s = 0; s < 16; s++)
         for (int k = 0; k < 4; k++) wr(waddr(s, k), pat(s, k, 9));
      check_all("R3", 1);
      check_all("R8", 1);

      // R5: wrong key, no key, intervening write
      wr(12'h300, KEYV ^ 32'h1); wr(12'h304, 32'h2);
      check_lock("R5", 1'b1);
      wr(12'h304, 32'h2);
      check_lock("R5", 1'b1);
      wr(12'h300, KEYV); wr(12'h310, 32'h0); wr(12'h304, 32'h2);
      check_lock("R5", 1'b1);
      wr(12'h300, KEYV); wr(12'h308, 32'h0); wr(12'h304, 32'h2);
      check_lock("R5", 1'b1);

      // R7: neither bit consumes key; R6: second command without key ignored
      wr(12'h300, KEYV); wr(12'h304, 32'h0);
      check_lock("R7", 1'b1);
      wr(12'h304, 32'h2);
      check_lock("R6", 1'b1);
      wr(12'h300, KEYV); wr(12'h304, 32'h2);
      check_lock("R4", 1'b0);
      wr(12'h304, 32'h1);
      check_lock("R6", 1'b0);

      // R8: unlocked read port, write sequence 15
      for (int k = 0; k < 4; k++) wr(waddr(15, k), pat(15, k, 3));
      check_row("R8", 15, 3);
      check_row("R1", 14, 1);

      // R7: both bits lock
      wr(12'h300, KEYV); wr(12'h304, 32'h3);
      check_lock("R7", 1'b1);
      wr(waddr(15, 0), 32'h1234_5678);
      check_row("R3", 15, 3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule